// File: doc/BRIEF.md
# Conditional-Sum Adder

This block adds two unsigned operands and a carry-in without a rippling carry chain. Each bit position first works out its result twice: once assuming a carry-in of 0 and once assuming a carry-in of 1. Adjacent groups are then joined level by level. At each level the group size doubles, and the lower group's pair of conditional carries picks between the upper group's two conditional results. After log2(WIDTH) levels one group spans the whole word, and it still holds two candidate answers. The real carry-in picks one of them.

The adder itself is purely combinational. In line with the surrounding FPGA fabric, the sum and the carry-out are captured in an output register with a synchronous active-high reset. The block accepts a new operand pair on every clock and returns each result exactly one clock later. WIDTH must be a power of two; the default is 8.

Top module: `csum_adder`

## Requirements
- R1: One rising clock edge after a_in, b_in and cin are sampled with rst low, the 9-bit value {cout_q, sum_q} equals the unsigned sum a_in + b_in + cin. This holds for every operand pair and both carry-in values.
- R2: When rst is high at a rising edge, sum_q and cout_q are both 0 after that edge, whatever the operand and carry-in values.
- R3: cout_q is 1 exactly when a_in + b_in + cin is at least 2^WIDTH. For example, 255+0+1 gives sum 0 with carry 1, 255+255+1 gives sum 255 with carry 1, and 128+127+0 gives sum 255 with carry 0.
- R4: For the same operands, the result with cin=1 is one greater, modulo 2^(WIDTH+1), than the result with cin=0. The carry-in selects only between the two precomputed whole-word results.
- R5: A new operand set may be applied on every clock. Results follow on consecutive clocks in the same order, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | WIDTH | First operand, unsigned |
| b_in | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum_q | output | WIDTH | Registered sum, low WIDTH bits |
| cout_q | output | 1 | Registered carry out of the top bit |

## Verification
Every result, including the cleared value after reset, is due one rising edge after its inputs are sampled. The bench drives each operand set on a falling edge and reads the outputs on the next falling edge, half a period after the capturing edge. A queue in the bench holds the expected value for each vector. One entry is pushed when a vector is driven and popped when its result is read, so back-to-back vectors are compared in order with no gaps. All 2^17 combinations of operands and carry-in are applied. Directed boundary, carry-in-pair and mid-run reset vectors follow.

// File: rtl/csum_pkg.sv
package csum_pkg;

  // Number of merge levels for a power-of-two width
  function automatic int merge_levels(input int width);
    return $clog2(width);
  endfunction

  // True when width is a non-zero power of two
  function automatic bit is_pow2(input int width);
    return (width > 0) && ((width & (width - 1)) == 0);
  endfunction

endpackage

// File: rtl/csum_bit_cell.sv
module csum_bit_cell (
  input  logic a,
  input  logic b,
  output logic sum_c0,
  output logic sum_c1,
  output logic cy_c0,
  output logic cy_c1
);

  logic diff;

  assign diff   = a ^ b;
  assign sum_c0 = diff;
  assign sum_c1 = ~diff;
  assign cy_c0  = a & b;
  assign cy_c1  = a | b;

  always_comb begin
    // R4
    cell_sum_pair_chk: assert ({cy_c1, sum_c1} == {cy_c0, sum_c0} + 2'd1);
    // R3
    cell_carry_order_chk: assert (!cy_c0 || cy_c1);
  end

endmodule

// File: rtl/csum_mux2.sv
module csum_mux2 #(
  parameter int W = 2
) (
  input  logic         sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  output logic [W-1:0] y
);

  assign y = sel ? d1 : d0;

endmodule

// File: rtl/csum_merge.sv
module csum_merge #(
  parameter int HW = 1
) (
  input  logic [HW-1:0]   lo_s0,
  input  logic [HW-1:0]   lo_s1,
  input  logic            lo_c0,
  input  logic            lo_c1,
  input  logic [HW-1:0]   hi_s0,
  input  logic [HW-1:0]   hi_s1,
  input  logic            hi_c0,
  input  logic            hi_c1,
  output logic [2*HW-1:0] m_s0,
  output logic [2*HW-1:0] m_s1,
  output logic            m_c0,
  output logic            m_c1
);

  localparam int UW = HW + 1;

  logic [UW-1:0] up_c0, up_c1;

  // Case "group carry-in 0": lower carry for cin=0 picks the upper result
  csum_mux2 #(.W(UW)) u_sel0 (
    .sel (lo_c0),
    .d0  ({hi_c0, hi_s0}),
    .d1  ({hi_c1, hi_s1}),
    .y   (up_c0)
  );

  // Case "group carry-in 1": lower carry for cin=1 picks the upper result
  csum_mux2 #(.W(UW)) u_sel1 (
    .sel (lo_c1),
    .d0  ({hi_c0, hi_s0}),
    .d1  ({hi_c1, hi_s1}),
    .y   (up_c1)
  );

  assign m_s0 = {up_c0[HW-1:0], lo_s0};
  assign m_s1 = {up_c1[HW-1:0], lo_s1};
  assign m_c0 = up_c0[HW];
  assign m_c1 = up_c1[HW];

  always_comb begin
    // R4
    merge_step_chk: assert ({m_c1, m_s1} == {m_c0, m_s0} + 1'b1);
  end

endmodule

// File: rtl/csum_adder.sv
module csum_adder
  import csum_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             cin,
  output logic [WIDTH-1:0] sum_q,
  output logic             cout_q
);

  localparam int LEVELS = merge_levels(WIDTH);
  localparam int TW     = WIDTH + 1;

  initial begin
    width_pow2_chk: assert (is_pow2(WIDTH));
  end

  for (genvar L = 0; L <= LEVELS; L++) begin : g_lv
    localparam int GW = 1 << L;
    localparam int NG = WIDTH / GW;

    logic [WIDTH-1:0] s0, s1;
    logic [NG-1:0]    c0, c1;

    if (L == 0) begin : g_leaf
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        csum_bit_cell u_cell (
          .a      (a_in[i]),
          .b      (b_in[i]),
          .sum_c0 (s0[i]),
          .sum_c1 (s1[i]),
          .cy_c0  (c0[i]),
          .cy_c1  (c1[i])
        );
      end
    end else begin : g_join
      localparam int HW = GW / 2;
      for (genvar g = 0; g < NG; g++) begin : g_grp
        csum_merge #(.HW(HW)) u_merge (
          .lo_s0 (g_lv[L-1].s0[(2*g)*HW +: HW]),
          .lo_s1 (g_lv[L-1].s1[(2*g)*HW +: HW]),
          .lo_c0 (g_lv[L-1].c0[2*g]),
          .lo_c1 (g_lv[L-1].c1[2*g]),
          .hi_s0 (g_lv[L-1].s0[(2*g+1)*HW +: HW]),
          .hi_s1 (g_lv[L-1].s1[(2*g+1)*HW +: HW]),
          .hi_c0 (g_lv[L-1].c0[2*g+1]),
          .hi_c1 (g_lv[L-1].c1[2*g+1]),
          .m_s0  (s0[g*GW +: GW]),
          .m_s1  (s1[g*GW +: GW]),
          .m_c0  (c0[g]),
          .m_c1  (c1[g])
        );
      end
    end
  end

  logic [TW-1:0] total;

  // Final pick between the two whole-word results
  csum_mux2 #(.W(TW)) u_final (
    .sel (cin),
    .d0  ({g_lv[LEVELS].c0[0], g_lv[LEVELS].s0}),
    .d1  ({g_lv[LEVELS].c1[0], g_lv[LEVELS].s1}),
    .y   (total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= total[WIDTH-1:0];
      cout_q <= total[WIDTH];
    end
  end

  // R1
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> ({cout_q, sum_q} ==
                ({1'b0, $past(a_in)} + {1'b0, $past(b_in)} + {{WIDTH{1'b0}}, $past(cin)})));

  // R3
  carry_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (cout_q == (($past(a_in) > ~$past(b_in)) ||
                           (($past(a_in) == ~$past(b_in)) && $past(cin)))));

endmodule

// File: tb/test_csum_adder.sv
module test_csum_adder;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum_q;
  logic         cout_q;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  int    exp_q[$];
  string tag_q[$];

  csum_adder #(.WIDTH(W)) i_csum_adder (
    .clk    (clk),
    .rst    (rst),
    .a_in   (a_in),
    .b_in   (b_in),
    .cin    (cin),
    .sum_q  (sum_q),
    .cout_q (cout_q)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected under 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check_val(input string tag, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Compare the result due now against the queue head
  task automatic compare_head();
    if (exp_q.size() > 0) begin
      int    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check_val(t, int'({cout_q, sum_q}), e);
    end
  endtask

  task automatic apply(input int a, input int b, input int c, input string tag);
    @(negedge clk);
    compare_head();
    a_in = W'(a);
    b_in = W'(b);
    cin  = c[0];
    exp_q.push_back(a + b + c);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk);
    compare_head();
  endtask

  initial begin
    // R2: reset state with nonzero inputs present
    a_in = 8'hA5; b_in = 8'h7E; cin = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R2 reset sum", int'(sum_q), 0);
    check_val("R2 reset carry", int'(cout_q), 0);
    rst = 1'b0;

    // R1: every operand pair and carry-in, back to back
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          apply(a, b, c, "R1");

    // R3: carry-out boundaries
    apply(255, 0, 1, "R3");
    apply(255, 255, 1, "R3");
    apply(128, 127, 0, "R3");
    apply(128, 128, 0, "R3");
    apply(0, 0, 0, "R3");
    apply(254, 1, 1, "R3");

    // R4: same operands, carry-in 0 then 1
    apply(85, 170, 0, "R4");
    apply(85, 170, 1, "R4");
    apply(15, 240, 0, "R4");
    apply(15, 240, 1, "R4");

    // R5: alternating patterns on consecutive cycles
    for (int k = 0; k < 16; k++)
      apply((k * 37) & 255, (k * 91 + 13) & 255, k & 1, "R5");
    drain();

    // R2: mid-run reset overrides live inputs
    @(negedge clk);
    rst  = 1'b1;
    a_in = 8'hFF; b_in = 8'hFF; cin = 1'b1;
    @(negedge clk);
    check_val("R2 mid-run sum", int'(sum_q), 0);
    check_val("R2 mid-run carry", int'(cout_q), 0);
    rst = 1'b0;
    apply(200, 100, 1, "R1");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule